// File: doc/BRIEF.md
# Interrupt Active-State Clear Register Bank

This block sits inside an interrupt distributor and gives software a window onto which interrupts are active. Each 32-bit register covers thirty-two consecutive interrupt numbers. Reading a register shows which of those interrupts are active. Writing ones removes the active state from the matching interrupts. Zero bits in the write data leave their interrupts unchanged. The active state itself is held inside the block. An activation input, driven by the delivery logic when a core acknowledges an interrupt, sets single bits.

The first register covers the core-private interrupts 0 to 31. It has a separate copy for each of eight cores, and the requesting core number on the bus selects the copy. Several conditions hide a bit from an access. A hidden bit reads as zero and ignores writes. The conditions are:
- the interrupt is not implemented;
- the requester is a non-secure core asking about a secure interrupt without permission;
- affinity routing owns the private interrupts of that security state;
- the requesting core has no copy of the first register.

The block is used for context save and restore, and to force-deactivate interrupts.

Top module: `irq_actclr_bank`

## Requirements
- R1: Register n sits at byte offset 0x380 + 4n, for n from 0 to LINE_COUNT. Bit x of register n reports and clears interrupt number 32n + x.
- R2: After reset every active bit is 0. While reset is held, and after it is released, reads return 0.
- R3: A read returns 1 in each bit whose interrupt is active and visible to the access, and 0 in every other bit.
- R4: Writing 1 to a bit makes that interrupt inactive. Writing 1 to an already inactive interrupt has no effect, and neither does writing 0 to any bit.
- R5: A pulse on `act_valid` marks interrupt `act_id` active, in the copy selected by `act_core` when the ID is below 32. When a register write clears the same bit in the same cycle, the clear wins and the bit ends inactive.
- R6: Interrupt numbers at or above IMPL_INTS read as 0 and ignore writes, and activation pulses for them are ignored.
- R7: Register 0 has one independent copy for each core from 0 to 7. Register 0 accesses from a core numbered 8 or above read as 0 and ignore writes. Activation pulses for IDs below 32 from such cores are ignored.
- R8: An interrupt is secure when it is Group 0 (`int_group1`=0) or Secure Group 1 (`int_group1`=1 and `int_grpmod`=1). When `sec_disable` is 0, a non-secure access (`bus_ns`=1) reads 0 and cannot clear a secure interrupt unless that interrupt's `int_ns_permit` bit is 1. When `sec_disable` is 1, security never hides a bit.
- R9: When `route_sec` is 1, register 0 bits of secure interrupts read as 0 and ignore writes. When `route_ns` is 1, the same applies to non-secure interrupts, and to all interrupts when `sec_disable` is 1. Registers 1 and up are not affected.
- R10: An access whose address is not 4-byte aligned, or lies outside 0x380 to 0x380 + 4*LINE_COUNT, reads as 0 and changes nothing.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled high, and is 0 in any cycle that does not follow a sampled read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_rd | input | 1 | Read enable |
| bus_wr | input | 1 | Write enable (write one to clear) |
| bus_wdata | input | 32 | Write data |
| bus_ns | input | 1 | 1 for a non-secure access |
| bus_core | input | CORE_W | Number of the requesting core |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| sec_disable | input | 1 | 1 disables the security split |
| route_sec | input | 1 | Affinity routing on for the secure state |
| route_ns | input | 1 | Affinity routing on for the non-secure state |
| int_group1 | input | 32*(LINE_COUNT+1) | Per-interrupt group bit (1 = Group 1) |
| int_grpmod | input | 32*(LINE_COUNT+1) | Per-interrupt group modifier (1 with Group 1 = secure) |
| int_ns_permit | input | 32*(LINE_COUNT+1) | Per-interrupt non-secure access permission |
| act_valid | input | 1 | Activation pulse |
| act_id | input | $clog2(32*(LINE_COUNT+1)) | Interrupt to activate |
| act_core | input | CORE_W | Core whose copy receives a private activation |

## Verification
A read sampled at one rising edge produces data at the next rising edge. One edge later the output returns to zero. Writes and activation pulses take effect at the edge where they are sampled. A read issued after that edge therefore sees their effect, and a read at the same edge still returns the old state. The driver raises each request shortly after an edge and queues the value the requirements predict. The monitor notes at the following falling edge that a read is pending, and pops and compares the queued value at the falling edge one cycle later. Every comparison therefore lands half a cycle after the data register has loaded.

// File: rtl/irq_actclr_pkg.sv
// Package: shared constants and helpers for the active-clear register bank.
// Assumes 32 interrupts per register and at most eight banked cores.
package irq_actclr_pkg;

    localparam int WORD_BITS   = 32;
    localparam int BANK_CORES  = 8;
    localparam int BANK_SEL_W  = 3;

    // Secure classification: Group 0, or Group 1 with the modifier set.
    function automatic logic int_is_secure(input logic grp1, input logic grpmod,
                                           input logic sec_dis);
        return !sec_dis && !(grp1 && !grpmod);
    endfunction

    // Mask of implemented bits inside register w for impl interrupts.
    function automatic logic [WORD_BITS-1:0] impl_mask(input int w, input int impl);
        logic [WORD_BITS-1:0] m;
        for (int b = 0; b < WORD_BITS; b++) begin
            m[b] = ((w * WORD_BITS + b) < impl);
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_actclr_mask.sv
// Module: per-bit visibility mask for one register access.
// Combines implementation, security, routing and banking rules into a
// 32-bit mask; a 0 bit means read-as-zero and write-ignored.
// Assumes word is forced to 0 by the caller when word_ok is low.
module irq_actclr_mask
    import irq_actclr_pkg::*;
#(
    parameter int NUM_INT   = 128,
    parameter int IMPL_INTS = 128,
    parameter int WORD_W    = 2
) (
    input  logic                 word_ok,
    input  logic [WORD_W-1:0]    word,
    input  logic                 core_ok,
    input  logic                 acc_ns,
    input  logic                 sec_disable,
    input  logic                 route_sec,
    input  logic                 route_ns,
    input  logic [NUM_INT-1:0]   int_group1,
    input  logic [NUM_INT-1:0]   int_grpmod,
    input  logic [NUM_INT-1:0]   int_ns_permit,
    output logic [WORD_BITS-1:0] vis_mask
);

    localparam int IDW = WORD_W + 5;

    logic is_word0;
    assign is_word0 = (word == '0);

    for (genvar b = 0; b < WORD_BITS; b++) begin : g_bit
        logic [IDW-1:0] id;
        logic           sec_int;
        logic           impl_ok;
        logic           sec_block;
        logic           route_block;

        // Build interrupt number and classify it for this access.
        always_comb begin
            id          = {word, 5'(b)};
            impl_ok     = (32'(id) < IMPL_INTS);
            sec_int     = int_is_secure(int_group1[id], int_grpmod[id], sec_disable);
            sec_block   = !sec_disable && acc_ns && sec_int && !int_ns_permit[id];
            route_block = is_word0 && (sec_int ? route_sec : route_ns);
            vis_mask[b] = word_ok && impl_ok && !sec_block && !route_block
                          && !(is_word0 && !core_ok);
        end
    end

endmodule

// File: rtl/irq_actclr_store.sv
// Module: active-state storage. Holds one private register per banked core
// and one shared register per upper word; sets from activation, clears
// from writes, clear winning. Assumes callers pre-qualify set_en and clr_bits.
module irq_actclr_store
    import irq_actclr_pkg::*;
#(
    parameter int LINE_COUNT = 3,
    parameter int IMPL_INTS  = 128,
    parameter int WORD_W     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_en,
    input  logic [WORD_W-1:0]     clr_word,
    input  logic [BANK_SEL_W-1:0] clr_bank,
    input  logic [WORD_BITS-1:0]  clr_bits,
    input  logic                  set_en,
    input  logic [WORD_W-1:0]     set_word,
    input  logic [4:0]            set_bit,
    input  logic [BANK_SEL_W-1:0] set_bank,
    input  logic [WORD_W-1:0]     rd_word,
    input  logic [BANK_SEL_W-1:0] rd_bank,
    output logic [WORD_BITS-1:0]  rd_vec
);

    localparam logic [WORD_BITS-1:0] MASK0 = impl_mask(0, IMPL_INTS);

    logic [WORD_BITS-1:0] bank_q [BANK_CORES];
    logic [WORD_BITS-1:0] shr_q  [1:LINE_COUNT];
    logic [WORD_BITS-1:0] set_one;

    assign set_one = WORD_BITS'(1) << set_bit;

    for (genvar c = 0; c < BANK_CORES; c++) begin : g_bank
        logic [WORD_BITS-1:0] s_v, c_v;
        // Select set and clear vectors aimed at this core's private copy.
        always_comb begin
            s_v = (set_en && set_word == '0 && set_bank == BANK_SEL_W'(c)) ? set_one : '0;
            c_v = (clr_en && clr_word == '0 && clr_bank == BANK_SEL_W'(c)) ? clr_bits : '0;
        end
        // Update the private copy; clear beats set.
        always_ff @(posedge clk) begin
            if (!rst_n) bank_q[c] <= '0;
            else        bank_q[c] <= (bank_q[c] | s_v) & ~c_v & MASK0;
        end
    end

    for (genvar w = 1; w <= LINE_COUNT; w++) begin : g_word
        localparam logic [WORD_BITS-1:0] MASKW = impl_mask(w, IMPL_INTS);
        logic [WORD_BITS-1:0] s_v, c_v;
        // Select set and clear vectors aimed at this shared register.
        always_comb begin
            s_v = (set_en && set_word == WORD_W'(w)) ? set_one : '0;
            c_v = (clr_en && clr_word == WORD_W'(w)) ? clr_bits : '0;
        end
        // Update the shared register; clear beats set.
        always_ff @(posedge clk) begin
            if (!rst_n) shr_q[w] <= '0;
            else        shr_q[w] <= (shr_q[w] | s_v) & ~c_v & MASKW;
        end
    end

    // Return the register addressed by the current access.
    always_comb begin
        if (rd_word == '0) rd_vec = bank_q[rd_bank];
        else               rd_vec = shr_q[rd_word];
    end

endmodule

// File: rtl/irq_actclr_bank.sv
// Module: top of the interrupt active-state clear register bank.
// Decodes the register window, forms the visibility mask, clears on
// write-one, sets on activation pulses and registers read data.
// Assumes LINE_COUNT >= 1 and CORE_W >= 3.
module irq_actclr_bank
    import irq_actclr_pkg::*;
#(
    parameter int LINE_COUNT = 3,
    parameter int IMPL_INTS  = 100,
    parameter int CORE_W     = 4,
    parameter int ADDR_W     = 12,
    parameter int BASE_OFF   = 'h380,
    localparam int NUM_INT   = WORD_BITS * (LINE_COUNT + 1),
    localparam int IDW       = $clog2(NUM_INT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_ns,
    input  logic [CORE_W-1:0]    bus_core,
    output logic [31:0]          bus_rdata,
    input  logic                 sec_disable,
    input  logic                 route_sec,
    input  logic                 route_ns,
    input  logic [NUM_INT-1:0]   int_group1,
    input  logic [NUM_INT-1:0]   int_grpmod,
    input  logic [NUM_INT-1:0]   int_ns_permit,
    input  logic                 act_valid,
    input  logic [IDW-1:0]       act_id,
    input  logic [CORE_W-1:0]    act_core
);

    localparam int WORD_W = IDW - 5;

    logic                 addr_ok;
    logic [WORD_W-1:0]    word;
    logic                 core_ok;
    logic                 set_ok;
    logic [WORD_BITS-1:0] vis_mask;
    logic [WORD_BITS-1:0] rd_vec;

    // Match the address against each aligned register offset.
    always_comb begin
        addr_ok = 1'b0;
        word    = '0;
        for (int w = 0; w <= LINE_COUNT; w++) begin
            if (bus_addr == ADDR_W'(BASE_OFF + 4 * w)) begin
                addr_ok = 1'b1;
                word    = WORD_W'(w);
            end
        end
    end

    // Qualify the requester and the activation pulse.
    always_comb begin
        core_ok = (32'(bus_core) < BANK_CORES);
        set_ok  = act_valid && (32'(act_id) < IMPL_INTS)
                  && ((act_id[IDW-1:5] != '0) || (32'(act_core) < BANK_CORES));
    end

    irq_actclr_mask #(
        .NUM_INT   (NUM_INT),
        .IMPL_INTS (IMPL_INTS),
        .WORD_W    (WORD_W)
    ) u_mask (
        .word_ok       (addr_ok),
        .word          (word),
        .core_ok       (core_ok),
        .acc_ns        (bus_ns),
        .sec_disable   (sec_disable),
        .route_sec     (route_sec),
        .route_ns      (route_ns),
        .int_group1    (int_group1),
        .int_grpmod    (int_grpmod),
        .int_ns_permit (int_ns_permit),
        .vis_mask      (vis_mask)
    );

    irq_actclr_store #(
        .LINE_COUNT (LINE_COUNT),
        .IMPL_INTS  (IMPL_INTS),
        .WORD_W     (WORD_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (bus_wr),
        .clr_word (word),
        .clr_bank (bus_core[BANK_SEL_W-1:0]),
        .clr_bits (bus_wdata & vis_mask),
        .set_en   (set_ok),
        .set_word (act_id[IDW-1:5]),
        .set_bit  (act_id[4:0]),
        .set_bank (act_core[BANK_SEL_W-1:0]),
        .rd_word  (word),
        .rd_bank  (bus_core[BANK_SEL_W-1:0]),
        .rd_vec   (rd_vec)
    );

    // Register masked read data; zero when no read was sampled.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_vec & vis_mask;
        else             bus_rdata <= '0;
    end

endmodule

// File: rtl/irq_actclr_chk.sv
// Module: assertion checker bound to irq_actclr_bank; watches only ports.
module irq_actclr_chk #(
    parameter int LINE_COUNT = 3,
    parameter int IMPL_INTS  = 100,
    parameter int CORE_W     = 4,
    parameter int ADDR_W     = 12,
    parameter int BASE_OFF   = 'h380
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CORE_W-1:0] bus_core,
    input logic              route_sec,
    input logic              route_ns,
    input logic [31:0]       bus_rdata
);

    localparam int TOP_BITS = IMPL_INTS - 32 * LINE_COUNT;
    localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(BASE_OFF);
    localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(BASE_OFF + 4 * LINE_COUNT);

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> bus_rdata == 32'h0);

    a_r10_misaligned_raz: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'h0);

    a_r7_foreign_core_raz: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr == A_FIRST && 32'(bus_core) >= 8) |-> bus_rdata == 32'h0);

    a_r9_routed_raz: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr == A_FIRST && route_sec && route_ns) |-> bus_rdata == 32'h0);

    a_r6_unimpl_raz: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr == A_LAST) |-> (64'(bus_rdata) >> TOP_BITS) == 64'h0);

endmodule

bind irq_actclr_bank irq_actclr_chk #(
    .LINE_COUNT (LINE_COUNT),
    .IMPL_INTS  (IMPL_INTS),
    .CORE_W     (CORE_W),
    .ADDR_W     (ADDR_W),
    .BASE_OFF   (BASE_OFF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_core  (bus_core),
    .route_sec (route_sec),
    .route_ns  (route_ns),
    .bus_rdata (bus_rdata)
);

// File: tb/tb_irq_actclr_bank.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor
// compares it one cycle after each sampled read.
module tb_irq_actclr_bank;

    localparam int NI = 128;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic            bus_rd = 1'b0;
    logic            bus_wr = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_ns = 1'b0;
    logic [3:0]      bus_core = '0;
    logic [31:0]     bus_rdata;
    logic            sec_disable = 1'b0;
    logic            route_sec = 1'b0;
    logic            route_ns = 1'b0;
    logic [NI-1:0]   int_group1 = '1;
    logic [NI-1:0]   int_grpmod = '0;
    logic [NI-1:0]   int_ns_permit = '0;
    logic            act_valid = 1'b0;
    logic [6:0]      act_id = '0;
    logic [3:0]      act_core = '0;

    int chk_cnt = 0;
    int fail_cnt = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        due = 1'b0;

    always #10 clk = ~clk;

    irq_actclr_bank #(.LINE_COUNT(3), .IMPL_INTS(100), .CORE_W(4),
                      .ADDR_W(12), .BASE_OFF('h380)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_ns(bus_ns),
        .bus_core(bus_core), .bus_rdata(bus_rdata), .sec_disable(sec_disable),
        .route_sec(route_sec), .route_ns(route_ns), .int_group1(int_group1),
        .int_grpmod(int_grpmod), .int_ns_permit(int_ns_permit),
        .act_valid(act_valid), .act_id(act_id), .act_core(act_core));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        chk_cnt++;
        if (got !== exp) begin
            fail_cnt++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_read(input logic [11:0] a, input logic ns, input logic [3:0] core,
                           input logic [31:0] exp, input string tag);
        tick();
        bus_addr = a; bus_ns = ns; bus_core = core; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [11:0] a, input logic ns, input logic [3:0] core,
                            input logic [31:0] d);
        tick();
        bus_addr = a; bus_ns = ns; bus_core = core; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic activate(input logic [6:0] id, input logic [3:0] core);
        tick();
        act_id = id; act_core = core; act_valid = 1'b1;
        tick();
        act_valid = 1'b0;
    endtask

    // Monitor: compare a queued value one cycle after each sampled read.
    always @(negedge clk) begin
        if (due) begin
            if (exp_q.size() == 0) check("monitor queue empty", bus_rdata, 32'hx);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
        due = bus_rd && rst_n;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        fail_cnt++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2 rdata in reset", bus_rdata, 32'h0);
        tick();
        rst_n = 1'b1;
        do_read(12'h380, 1'b0, 4'd0, 32'h0, "R2 word0 after reset");
        do_read(12'h384, 1'b0, 4'd0, 32'h0, "R2 word1 after reset");

        activate(7'd40, 4'd0); activate(7'd41, 4'd0); activate(7'd45, 4'd0);
        do_read(12'h384, 1'b1, 4'd0, 32'h0000_2300, "R1 R3 R5 ids 40 41 45");
        // R11: the output falls back to zero one cycle after the read data.
        @(negedge clk); @(negedge clk);
        check("R11 rdata idle after read", bus_rdata, 32'h0);

        do_write(12'h384, 1'b1, 4'd0, 32'h0000_0201);
        do_read(12'h384, 1'b1, 4'd0, 32'h0000_2100, "R4 clear 41, inactive 32 untouched");

        activate(7'd5, 4'd2); activate(7'd7, 4'd0); activate(7'd3, 4'd9);
        do_read(12'h380, 1'b1, 4'd2, 32'h0000_0020, "R7 core2 copy");
        do_read(12'h380, 1'b1, 4'd0, 32'h0000_0080, "R7 core0 copy");
        do_read(12'h380, 1'b1, 4'd1, 32'h0000_0000, "R7 core9 activation ignored");
        do_read(12'h380, 1'b1, 4'd9, 32'h0000_0000, "R7 core9 read as zero");
        do_write(12'h380, 1'b1, 4'd9, 32'hFFFF_FFFF);
        do_read(12'h380, 1'b1, 4'd2, 32'h0000_0020, "R7 core9 write ignored");

        activate(7'd99, 4'd0); activate(7'd100, 4'd0);
        do_read(12'h38C, 1'b1, 4'd0, 32'h0000_0008, "R6 id100 not implemented");
        do_read(12'h390, 1'b1, 4'd0, 32'h0, "R10 beyond last register");
        do_read(12'h385, 1'b1, 4'd0, 32'h0, "R10 misaligned read");
        do_write(12'h385, 1'b1, 4'd0, 32'hFFFF_FFFF);
        do_read(12'h384, 1'b1, 4'd0, 32'h0000_2100, "R10 misaligned write ignored");

        int_group1[45] = 1'b0;
        do_read(12'h384, 1'b1, 4'd0, 32'h0000_0100, "R8 ns hides group0");
        do_read(12'h384, 1'b0, 4'd0, 32'h0000_2100, "R8 secure sees group0");
        do_write(12'h384, 1'b1, 4'd0, 32'h0000_2000);
        do_read(12'h384, 1'b0, 4'd0, 32'h0000_2100, "R8 ns clear ignored");
        int_ns_permit[45] = 1'b1;
        do_read(12'h384, 1'b1, 4'd0, 32'h0000_2100, "R8 ns permitted");
        int_ns_permit[45] = 1'b0;
        sec_disable = 1'b1;
        do_read(12'h384, 1'b1, 4'd0, 32'h0000_2100, "R8 security disabled");
        sec_disable = 1'b0;
        int_grpmod[40] = 1'b1;
        do_read(12'h384, 1'b1, 4'd0, 32'h0000_0000, "R8 secure group1 hidden");
        int_grpmod[40] = 1'b0;
        int_group1[45] = 1'b1;

        route_ns = 1'b1;
        do_read(12'h380, 1'b1, 4'd0, 32'h0, "R9 ns routing hides word0");
        do_read(12'h380, 1'b0, 4'd0, 32'h0, "R9 ns routing hides for secure access");
        do_read(12'h384, 1'b1, 4'd0, 32'h0000_2100, "R9 word1 unaffected");
        do_write(12'h380, 1'b1, 4'd0, 32'h0000_0080);
        route_ns = 1'b0;
        do_read(12'h380, 1'b1, 4'd0, 32'h0000_0080, "R9 routed write ignored");
        int_group1[5] = 1'b0;
        route_sec = 1'b1;
        do_read(12'h380, 1'b0, 4'd2, 32'h0, "R9 secure routing hides group0");
        route_sec = 1'b0;
        do_read(12'h380, 1'b0, 4'd2, 32'h0000_0020, "R9 secure routing off");
        int_group1[5] = 1'b1;
        do_write(12'h380, 1'b0, 4'd0, 32'h0000_0080);
        do_read(12'h380, 1'b0, 4'd0, 32'h0, "R4 word0 core0 cleared");

        // R5: clear and set of the same bit in one cycle, clear wins.
        tick();
        bus_addr = 12'h384; bus_ns = 1'b0; bus_core = 4'd0;
        bus_wdata = 32'h0000_0100; bus_wr = 1'b1;
        act_id = 7'd40; act_core = 4'd0; act_valid = 1'b1;
        tick();
        bus_wr = 1'b0; act_valid = 1'b0;
        do_read(12'h384, 1'b0, 4'd0, 32'h0000_2000, "R5 clear beats set");
        activate(7'd40, 4'd0);
        do_read(12'h384, 1'b0, 4'd0, 32'h0000_2100, "R5 set after collision");
        do_write(12'h384, 1'b0, 4'd0, 32'hFFFF_FFFF);
        do_read(12'h384, 1'b0, 4'd0, 32'h0, "R4 clear all");

        repeat (3) tick();
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    end

endmodule